// File: doc/BRIEF.md
# Two-Pin Interrupt Vector Router

This block sits between two local interrupt input pins and a processor core. It turns each rising edge on a pin into one vectored interrupt request: a valid flag, an 8-bit vector and a flag that marks a non-maskable request. The request is held until the core accepts it.

A global mode input picks what the pins mean. In programmable mode each pin has its own table entry holding a vector and a mask bit, and the entry supplies the vector for that pin. Writes that try to place a vector in the range reserved for architectural exceptions (below 32) are refused. A sticky flag records the refusal.

In legacy mode pin 1 is the non-maskable line and always delivers vector 2. Pin 0 is the maskable external line and is gated by the core's interrupt-enable input. For pin 0 the vector comes from an outside interrupt controller: the block raises an acknowledge and waits for a strobe that carries the vector.

Top module: `pin_irq_router`

## Requirements
- R1: After reset, `irq_valid`, `xc_ack` and `cfg_bad_vec` are 0, and both table entries are masked, holding vector 32 (0x20).
- R2: In programmable mode (`prog_mode`=1), a rising edge on an unmasked pin yields `irq_valid`=1 two clock edges later, with `irq_vec` equal to that pin's entry vector and `irq_nmi`=0.
- R3: A request holds `irq_valid`, `irq_vec` and `irq_nmi` steady until `irq_accept` is high at a clock edge. Each rising edge yields exactly one request, so a pin held high does not repeat.
- R4: A table write (`cfg_we`=1, entry `cfg_sel`) whose `cfg_vec` is below 32 leaves the entry unchanged and sets `cfg_bad_vec`. The flag stays set until reset, and a write of 32 or more updates both the vector and the mask bit.
- R5: In programmable mode, an edge on a masked pin produces no request, and that edge is not delivered after the pin is later unmasked.
- R6: In legacy mode (`prog_mode`=0), an edge on pin 1 yields a request with `irq_vec`=2 and `irq_nmi`=1 whatever the value of `core_ie`.
- R7: In legacy mode, an edge on pin 0 with `core_ie`=1 raises `xc_ack`, which holds until `xc_vec_valid` arrives. On the next edge the block presents `xc_vec` with `irq_nmi`=0 and drops `xc_ack`.
- R8: In legacy mode, a pin 0 edge taken while `core_ie`=0 stays pending with `xc_ack` low, and it is served once `core_ie` returns to 1.
- R9: When both pins present requests in the same cycle, pin 1's request is presented first and pin 0's request stays pending until the first one is accepted.
- R10: In legacy mode the table mask bits have no effect on either pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | 1: vectors come from the table; 0: legacy maskable/non-maskable pins |
| pin_in | input | 2 | Local interrupt pins, rising-edge triggered |
| core_ie | input | 1 | Core interrupt enable, gates the legacy maskable line |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | Table entry selected by the write (pin number) |
| cfg_vec | input | 8 | Vector to write |
| cfg_mask | input | 1 | Mask bit to write |
| cfg_bad_vec | output | 1 | Sticky flag set by a refused write |
| xc_ack | output | 1 | Acknowledge to the external controller, high while a vector is awaited |
| xc_vec_valid | input | 1 | Strobe from the external controller that marks the vector valid |
| xc_vec | input | 8 | Vector from the external controller |
| irq_valid | output | 1 | Request to the core is valid |
| irq_vec | output | 8 | Request vector |
| irq_nmi | output | 1 | Request is non-maskable |
| irq_accept | input | 1 | Core takes the current request |

## Verification
The bench targets a vector below 32 written to the table. A design that let it through would deliver an exception vector from a device pin, and one that updated the mask alone would change which pin fires. It masks a pin, pulses it, and then unmasks it. A design that remembered the masked edge would raise a late request. Both pins are asserted in the same cycle in legacy mode: a wrong priority would show a vector other than 2 first, and a design that lost the second request would never raise the acknowledge afterwards. The acknowledge handshake is held open for several cycles with `core_ie` toggled around it, which catches a design that times out, presents a stale vector, or lets the interrupt-enable gate the non-maskable line.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int PIR_NPIN    = 2;
  localparam int PIR_PIN_MI  = 0;
  localparam int PIR_PIN_NMI = 1;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_PRESENT = 2'd2
  } pir_state_e;
endpackage

// File: rtl/pir_edge_latch.sv
module pir_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic block,
  input  logic clr,
  output logic pend
);
  logic pin_q;
  logic pend_q, pend_n;
  logic rise;

  assign rise = pin & ~pin_q;

  always_comb begin
    pend_n = pend_q;
    if (clr)   pend_n = 1'b0;
    if (rise)  pend_n = 1'b1;
    if (block) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pin_q  <= pin;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/pir_vec_table.sv
module pir_vec_table #(
  parameter int VEC_W        = 8,
  parameter int NPIN         = 2,
  parameter int MIN_USER_VEC = 32,
  parameter int RESET_VEC    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [$clog2(NPIN)-1:0]    sel,
  input  logic [VEC_W-1:0]           wvec,
  input  logic                       wmask,
  output logic [NPIN-1:0][VEC_W-1:0] ent_vec,
  output logic [NPIN-1:0]            ent_mask,
  output logic                       bad_flag
);
  localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_USER_VEC);
  localparam logic [VEC_W-1:0] RST_V = VEC_W'(RESET_VEC);

  logic legal;
  logic bad_q, bad_n;

  assign legal = (wvec >= MIN_V);

  always_comb begin
    bad_n = bad_q;
    if (we && !legal) bad_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_n;
  end

  assign bad_flag = bad_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_ent
    logic             en;
    logic [VEC_W-1:0] vec_q;
    logic             mask_q;

    assign en = we && legal && (sel == ($clog2(NPIN))'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q  <= RST_V;
        mask_q <= 1'b1;
      end else if (en) begin
        vec_q  <= wvec;
        mask_q <= wmask;
      end
    end

    assign ent_vec[g]  = vec_q;
    assign ent_mask[g] = mask_q;
  end
endmodule

// File: rtl/pir_delivery.sv
module pir_delivery
  import pir_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           prog_mode,
  input  logic                           core_ie,
  input  logic [PIR_NPIN-1:0]            pend,
  input  logic [PIR_NPIN-1:0][VEC_W-1:0] tab_vec,
  input  logic                           ext_valid,
  input  logic [VEC_W-1:0]               ext_vec,
  input  logic                           accept,
  output logic [PIR_NPIN-1:0]            clr,
  output logic                           ack,
  output logic                           valid,
  output logic [VEC_W-1:0]               vec,
  output logic                           nmi
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

  pir_state_e       st_q, st_n;
  logic [VEC_W-1:0] vec_q, vec_n;
  logic             nmi_q, nmi_n;

  always_comb begin
    st_n  = st_q;
    vec_n = vec_q;
    nmi_n = nmi_q;
    clr   = '0;
    case (st_q)
      ST_IDLE: begin
        if (pend[PIR_PIN_NMI]) begin
          clr[PIR_PIN_NMI] = 1'b1;
          st_n             = ST_PRESENT;
          if (prog_mode) begin
            vec_n = tab_vec[PIR_PIN_NMI];
            nmi_n = 1'b0;
          end else begin
            vec_n = NMI_V;
            nmi_n = 1'b1;
          end
        end else if (pend[PIR_PIN_MI]) begin
          if (prog_mode) begin
            clr[PIR_PIN_MI] = 1'b1;
            st_n            = ST_PRESENT;
            vec_n           = tab_vec[PIR_PIN_MI];
            nmi_n           = 1'b0;
          end else if (core_ie) begin
            clr[PIR_PIN_MI] = 1'b1;
            st_n            = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (ext_valid) begin
          vec_n = ext_vec;
          nmi_n = 1'b0;
          st_n  = ST_PRESENT;
        end
      end
      ST_PRESENT: begin
        if (accept) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vec_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      vec_q <= vec_n;
      nmi_q <= nmi_n;
    end
  end

  assign ack   = (st_q == ST_FETCH);
  assign valid = (st_q == ST_PRESENT);
  assign vec   = vec_q;
  assign nmi   = nmi_q;
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
  import pir_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int MIN_USER_VEC = 32,
  parameter int RESET_VEC    = 32,
  parameter int NMI_VEC      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_mode,
  input  logic [PIR_NPIN-1:0] pin_in,
  input  logic                core_ie,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [VEC_W-1:0]    cfg_vec,
  input  logic                cfg_mask,
  output logic                cfg_bad_vec,
  output logic                xc_ack,
  input  logic                xc_vec_valid,
  input  logic [VEC_W-1:0]    xc_vec,
  output logic                irq_valid,
  output logic [VEC_W-1:0]    irq_vec,
  output logic                irq_nmi,
  input  logic                irq_accept
);
  logic [PIR_NPIN-1:0][VEC_W-1:0] ent_vec;
  logic [PIR_NPIN-1:0]            ent_mask;
  logic [PIR_NPIN-1:0]            pend;
  logic [PIR_NPIN-1:0]            clr;

  pir_vec_table #(
    .VEC_W       (VEC_W),
    .NPIN        (PIR_NPIN),
    .MIN_USER_VEC(MIN_USER_VEC),
    .RESET_VEC   (RESET_VEC)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wvec    (cfg_vec),
    .wmask   (cfg_mask),
    .ent_vec (ent_vec),
    .ent_mask(ent_mask),
    .bad_flag(cfg_bad_vec)
  );

  for (genvar g = 0; g < PIR_NPIN; g++) begin : g_pin
    pir_edge_latch u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_in[g]),
      .block(prog_mode & ent_mask[g]),
      .clr  (clr[g]),
      .pend (pend[g])
    );
  end

  pir_delivery #(
    .VEC_W  (VEC_W),
    .NMI_VEC(NMI_VEC)
  ) u_deliver (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_mode(prog_mode),
    .core_ie  (core_ie),
    .pend     (pend),
    .tab_vec  (ent_vec),
    .ext_valid(xc_vec_valid),
    .ext_vec  (xc_vec),
    .accept   (irq_accept),
    .clr      (clr),
    .ack      (xc_ack),
    .valid    (irq_valid),
    .vec      (irq_vec),
    .nmi      (irq_nmi)
  );
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
  parameter int VEC_W        = 8,
  parameter int MIN_USER_VEC = 32,
  parameter int NMI_VEC      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [VEC_W-1:0] cfg_vec,
  input logic             cfg_bad_vec,
  input logic             xc_ack,
  input logic             xc_vec_valid,
  input logic [VEC_W-1:0] xc_vec,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_nmi,
  input logic             irq_accept
);
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_accept |=> irq_valid && $stable(irq_vec) && $stable(irq_nmi));

  p_bad_write_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_vec < VEC_W'(MIN_USER_VEC)) |=> cfg_bad_vec);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad_vec |=> cfg_bad_vec);

  p_nmi_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_nmi |-> irq_vec == VEC_W'(NMI_VEC));

  p_ack_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xc_ack && !xc_vec_valid |=> xc_ack && !irq_valid);

  p_ack_delivers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xc_ack && xc_vec_valid |=> irq_valid && !xc_ack && !irq_nmi && irq_vec == $past(xc_vec));

  p_ack_excl_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(xc_ack && irq_valid));
endmodule

bind pin_irq_router pir_checker #(
  .VEC_W       (VEC_W),
  .MIN_USER_VEC(MIN_USER_VEC),
  .NMI_VEC     (NMI_VEC)
) u_pir_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_vec     (cfg_vec),
  .cfg_bad_vec (cfg_bad_vec),
  .xc_ack      (xc_ack),
  .xc_vec_valid(xc_vec_valid),
  .xc_vec      (xc_vec),
  .irq_valid   (irq_valid),
  .irq_vec     (irq_vec),
  .irq_nmi     (irq_nmi),
  .irq_accept  (irq_accept)
);

// File: tb/test_pin_irq_router.sv
module test_pin_irq_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_mode = 1'b0;
  logic [1:0] pin_in = 2'b00;
  logic       core_ie = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_vec = 8'h00;
  logic       cfg_mask = 1'b0;
  logic       cfg_bad_vec;
  logic       xc_ack;
  logic       xc_vec_valid = 1'b0;
  logic [7:0] xc_vec = 8'h00;
  logic       irq_valid;
  logic [7:0] irq_vec;
  logic       irq_nmi;
  logic       irq_accept = 1'b0;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pin_irq_router i_pin_irq_router (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .pin_in(pin_in),
    .core_ie(core_ie), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_vec(cfg_vec),
    .cfg_mask(cfg_mask), .cfg_bad_vec(cfg_bad_vec), .xc_ack(xc_ack),
    .xc_vec_valid(xc_vec_valid), .xc_vec(xc_vec), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_nmi(irq_nmi), .irq_accept(irq_accept)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input bit sel, input logic [7:0] v, input bit m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_vec = v; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] p);
    @(negedge clk);
    pin_in = p;
    @(negedge clk);
    pin_in = 2'b00;
  endtask

  task automatic accept_req();
    irq_accept = 1'b1;
    @(negedge clk);
    irq_accept = 1'b0;
  endtask

  task automatic t_reset();
    chk(irq_valid == 1'b0, "R1 valid", int'(irq_valid), 0);
    chk(xc_ack == 1'b0, "R1 ack", int'(xc_ack), 0);
    chk(cfg_bad_vec == 1'b0, "R1 flag", int'(cfg_bad_vec), 0);
    prog_mode = 1'b1;
    pulse(2'b01);
    cyc(4);
    chk(irq_valid == 1'b0, "R1 reset entry masked", int'(irq_valid), 0);
  endtask

  task automatic t_prog_basic();
    prog_mode = 1'b1;
    cfg_write(1'b0, 8'h41, 1'b0);
    cfg_write(1'b1, 8'hC7, 1'b0);
    @(negedge clk);
    pin_in = 2'b01;
    @(negedge clk);
    chk(irq_valid == 1'b0, "R2 latency one edge", int'(irq_valid), 0);
    @(negedge clk);
    chk(irq_valid == 1'b1, "R2 valid after two edges", int'(irq_valid), 1);
    chk(irq_vec == 8'h41, "R2 pin0 vector", int'(irq_vec), 'h41);
    chk(irq_nmi == 1'b0, "R2 nmi low", int'(irq_nmi), 0);
    cyc(3);
    chk(irq_valid == 1'b1 && irq_vec == 8'h41, "R3 held until accept", int'(irq_vec), 'h41);
    accept_req();
    chk(irq_valid == 1'b0, "R3 cleared by accept", int'(irq_valid), 0);
    cyc(5);
    chk(irq_valid == 1'b0, "R3 held pin no repeat", int'(irq_valid), 0);
    pin_in = 2'b00;
    pulse(2'b10);
    cyc(1);
    chk(irq_valid == 1'b1 && irq_vec == 8'hC7, "R2 pin1 vector", int'(irq_vec), 'hC7);
    accept_req();
  endtask

  task automatic t_bad_write();
    cfg_write(1'b0, 8'h1F, 1'b1);
    chk(cfg_bad_vec == 1'b1, "R4 flag set", int'(cfg_bad_vec), 1);
    pulse(2'b01);
    cyc(1);
    chk(irq_valid == 1'b1 && irq_vec == 8'h41, "R4 old entry kept", int'(irq_vec), 'h41);
    accept_req();
    cfg_write(1'b0, 8'h20, 1'b0);
    chk(cfg_bad_vec == 1'b1, "R4 flag sticky", int'(cfg_bad_vec), 1);
    pulse(2'b01);
    cyc(1);
    chk(irq_vec == 8'h20, "R4 boundary 32 accepted", int'(irq_vec), 'h20);
    accept_req();
  endtask

  task automatic t_mask();
    cfg_write(1'b1, 8'h90, 1'b1);
    pulse(2'b10);
    cyc(4);
    chk(irq_valid == 1'b0, "R5 masked no request", int'(irq_valid), 0);
    cfg_write(1'b1, 8'h90, 1'b0);
    cyc(4);
    chk(irq_valid == 1'b0, "R5 masked edge forgotten", int'(irq_valid), 0);
  endtask

  task automatic t_legacy_nmi();
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    prog_mode = 1'b0;
    core_ie = 1'b0;
    pulse(2'b10);
    cyc(1);
    chk(irq_valid == 1'b1, "R6 nmi ignores ie", int'(irq_valid), 1);
    chk(irq_vec == 8'd2, "R6 nmi vector", int'(irq_vec), 2);
    chk(irq_nmi == 1'b1, "R6 nmi flag", int'(irq_nmi), 1);
    chk(irq_valid == 1'b1, "R10 table mask ignored in legacy", int'(irq_valid), 1);
    accept_req();
  endtask

  task automatic t_ie_gate();
    core_ie = 1'b0;
    pulse(2'b01);
    cyc(5);
    chk(xc_ack == 1'b0 && irq_valid == 1'b0, "R8 held while ie low", int'(xc_ack), 0);
    core_ie = 1'b1;
    @(negedge clk);
    chk(xc_ack == 1'b1, "R8 served when ie high", int'(xc_ack), 1);
    cyc(4);
    chk(xc_ack == 1'b1 && irq_valid == 1'b0, "R7 ack waits", int'(xc_ack), 1);
    xc_vec_valid = 1'b1; xc_vec = 8'h5A;
    @(negedge clk);
    xc_vec_valid = 1'b0; xc_vec = 8'h00;
    chk(irq_valid == 1'b1 && irq_vec == 8'h5A, "R7 external vector", int'(irq_vec), 'h5A);
    chk(irq_nmi == 1'b0 && xc_ack == 1'b0, "R7 nmi low ack dropped", int'(xc_ack), 0);
    chk(irq_valid == 1'b1, "R10 pin0 mask ignored in legacy", int'(irq_valid), 1);
    accept_req();
  endtask

  task automatic t_both();
    core_ie = 1'b1;
    pulse(2'b11);
    cyc(1);
    chk(irq_valid == 1'b1 && irq_nmi == 1'b1 && irq_vec == 8'd2, "R9 nmi first", int'(irq_vec), 2);
    cyc(2);
    chk(xc_ack == 1'b0, "R9 second waits for accept", int'(xc_ack), 0);
    accept_req();
    @(negedge clk);
    chk(xc_ack == 1'b1, "R9 pending maskable served", int'(xc_ack), 1);
    xc_vec_valid = 1'b1; xc_vec = 8'hE3;
    @(negedge clk);
    xc_vec_valid = 1'b0;
    chk(irq_valid == 1'b1 && irq_vec == 8'hE3, "R9 second vector", int'(irq_vec), 'hE3);
    accept_req();
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_prog_basic();
    t_bad_write();
    t_mask();
    t_legacy_nmi();
    t_ie_gate();
    t_both();
    cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule